// File: doc/BRIEF.md
# Cycle-Typed Memory Controller

This block sits on the memory side of a 32-bit processor bus and serves byte, halfword and word transfers from a local word array. Every cycle the core presents a two-bit cycle code made of the active-low request line and the sequential flag. This code tells a new unrelated access apart from a follow-on access, and it also marks cycles that do no memory work: internal cycles, and coprocessor transfers that use the data bus without the memory. The core runs on the memory clock gated by `wait_o`. While `wait_o` is high the core holds every input steady, and the access completes on the first rising edge with `wait_o` low.

Unrelated accesses cost two wait cycles. A follow-on access costs none when its address stays within one halfword step or one word step of the last completed address. A locked swap may do its write straight after its read with no wait, because the bus stays held between the two phases. Misaligned accesses and the reserved size code are rejected in the cycle they appear. The byte order inside each word follows a configuration input. On narrow reads the selected lanes are repeated across the whole read bus.

Top module: `bus_cycle_mem`

## Requirements
- R1: The code {mreq_ni, seq_i} is decoded as 00 non-sequential, 01 sequential, 10 internal and 11 coprocessor. Only 00 and 01 are memory accesses.
- R2: A non-sequential access that is not rejected holds `wait_o` high for exactly 2 cycles. It completes on the edge after the second wait cycle.
- R3: A sequential access completes with no wait when a last completed address exists and the new address equals it, or is 2 above it, or is 4 above it. In every other case the access is timed as non-sequential (R2).
- R4: Internal and coprocessor cycles never write memory and do not change the last completed address. They drive `wait_o`=0, `abort_o`=0 and `rdata_o`=0.
- R5: size_i 00 is byte, 01 is halfword and 10 is word. Size 11 is rejected.
- R6: A word access with addr_i[1:0]≠0, a halfword access with addr_i[0]=1, or size 11 raises `abort_o` in that cycle with `wait_o`=0. The access writes nothing, returns `rdata_o`=0 and leaves the last completed address unchanged.
- R7: With big_end_i=0, byte k of a word sits at bits [8k+7:8k]. With big_end_i=1, it sits at bits [31-8k:24-8k]. A halfword follows the same rule by halves.
- R8: A byte read returns the selected byte 4 times across `rdata_o`, and a halfword read returns it twice. A write returns `rdata_o`=0.
- R9: If the last completed access was a read made with lock_i=1, and lock_i has stayed high since, then a write to the same address completes with no wait, whatever its cycle code.
- R10: Reset clears the last completed address, the wait count and the lock hold, but keeps the memory contents. The first sequential access after reset is timed as non-sequential.
- R11: A byte write takes wdata_i[7:0] and a halfword write takes wdata_i[15:0]. Lanes outside the access keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Byte address |
| mreq_ni | input | 1 | Active-low memory request (cycle code bit 1) |
| seq_i | input | 1 | Sequential flag (cycle code bit 0) |
| wr_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| lock_i | input | 1 | Holds the bus for a swap read/write pair |
| big_end_i | input | 1 | 1 = big-endian lane order |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the completing cycle |
| wait_o | output | 1 | Stretches the current cycle |
| abort_o | output | 1 | Rejects a misaligned or reserved-size access |

## Verification
The timing path and the rejection path both act in the same cycle. A sequential-coded access can be both near the last address and misaligned, and a locked write can arrive with a non-sequential code. The vectors place a misaligned halfword write at exactly prev+1 under the sequential code. It must abort with no wait and must not move the last address: the next sequential read at the old address then has to complete at once. A locked write with code 00 straight after a locked read must finish with zero waits, while the same write without the lock hold must take two.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int BUS_W  = 32;
  localparam int NLANE  = BUS_W / 8;

  typedef enum logic [1:0] {
    CYC_NSEQ = 2'b00,
    CYC_SEQ  = 2'b01,
    CYC_INT  = 2'b10,
    CYC_COP  = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;
endpackage

// File: rtl/mic_lanes.sv
module mic_lanes
  import mic_pkg::*;
(
  input  logic [1:0]       off_i,
  input  size_e            size_i,
  input  logic             big_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] word_i,
  output logic             bad_o,
  output logic [BUS_W-1:0] merged_o,
  output logic [BUS_W-1:0] rrep_o
);
  logic [1:0]       lane;
  logic             hsel;
  logic [BUS_W-1:0] wrep;
  logic [NLANE-1:0] mask;

  assign lane = big_i ? ~off_i : off_i;
  assign hsel = big_i ? ~off_i[1] : off_i[1];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: bad_o = 1'b0;
      SZ_HALF: bad_o = off_i[0];
      SZ_WORD: bad_o = |off_i;
      default: bad_o = 1'b1;
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        wrep   = {NLANE{wdata_i[7:0]}};
        rrep_o = {NLANE{word_i[8*lane +: 8]}};
      end
      SZ_HALF: begin
        wrep   = {(NLANE/2){wdata_i[15:0]}};
        rrep_o = {(NLANE/2){word_i[16*hsel +: 16]}};
      end
      default: begin
        wrep   = wdata_i;
        rrep_o = word_i;
      end
    endcase
  end

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    localparam logic [1:0] LB = 2'(b);
    assign mask[b] = (size_i == SZ_WORD) ||
                     (size_i == SZ_HALF && LB[1] == hsel) ||
                     (size_i == SZ_BYTE && LB == lane);
    assign merged_o[8*b +: 8] = mask[b] ? wrep[8*b +: 8] : word_i[8*b +: 8];
  end
endmodule

// File: rtl/mic_store.sv
module mic_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mic_cycle_ctrl.sv
module mic_cycle_ctrl
  import mic_pkg::*;
#(
  parameter int AW     = 32,
  parameter int WAIT_N = 2,
  parameter int CW     = $clog2(WAIT_N + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_e          cyc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          lock_i,
  input  logic          bad_i,
  output logic          wait_o,
  output logic          abort_o,
  output logic          go_o
);
  logic [AW-1:0] prev_q;
  logic          prev_vld_q;
  logic          lock_held_q;
  logic [CW-1:0] cnt_q;
  logic          req, near, swap_wr, fast;

  assign req     = (cyc_i == CYC_NSEQ) || (cyc_i == CYC_SEQ);
  assign near    = prev_vld_q && ((addr_i == prev_q) ||
                                  (addr_i == prev_q + AW'(2)) ||
                                  (addr_i == prev_q + AW'(4)));
  assign swap_wr = lock_held_q && lock_i && wr_i && (addr_i == prev_q);
  assign fast    = ((cyc_i == CYC_SEQ) && near) || swap_wr;

  assign abort_o = req && bad_i;
  assign wait_o  = req && !bad_i && !fast && (cnt_q != CW'(WAIT_N));
  assign go_o    = req && !bad_i && !wait_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      prev_q      <= '0;
      prev_vld_q  <= 1'b0;
      lock_held_q <= 1'b0;
    end else begin
      cnt_q <= wait_o ? cnt_q + CW'(1) : '0;
      if (go_o) begin
        prev_q      <= addr_i;
        prev_vld_q  <= 1'b1;
        lock_held_q <= lock_i && !wr_i;
      end else if (!lock_i) begin
        lock_held_q <= 1'b0;
      end
    end
  end

  // R2: the core holds its request while stretched
  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> $stable(addr_i) && $stable(cyc_i));

  // R2: a stretched access either keeps waiting or completes
  a_r2_wait_resolves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> (wait_o || go_o));

  // R6: a rejected cycle never stalls
  a_r6_abort_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !wait_o && !go_o);
endmodule

// File: rtl/bus_cycle_mem.sv
module bus_cycle_mem
  import mic_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WAIT_N = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  input  logic        mreq_ni,
  input  logic        seq_i,
  input  logic        wr_i,
  input  logic [1:0]  size_i,
  input  logic        lock_i,
  input  logic        big_end_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        wait_o,
  output logic        abort_o
);
  localparam int IW = $clog2(DEPTH);

  cyc_e             cyc;
  size_e            size;
  logic             bad, go, we;
  logic [IW-1:0]    idx;
  logic [BUS_W-1:0] word, merged, rrep;

  assign cyc  = cyc_e'({mreq_ni, seq_i});
  assign size = size_e'(size_i);
  assign idx  = addr_i[IW+1:2];

  mic_cycle_ctrl #(.AW(32), .WAIT_N(WAIT_N)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_i  (cyc),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .lock_i (lock_i),
    .bad_i  (bad),
    .wait_o (wait_o),
    .abort_o(abort_o),
    .go_o   (go)
  );

  mic_lanes lanes_i (
    .off_i   (addr_i[1:0]),
    .size_i  (size),
    .big_i   (big_end_i),
    .wdata_i (wdata_i),
    .word_i  (word),
    .bad_o   (bad),
    .merged_o(merged),
    .rrep_o  (rrep)
  );

  assign we = go && wr_i;

  mic_store #(.DEPTH(DEPTH), .DW(BUS_W)) store_i (
    .clk_i  (clk_i),
    .we_i   (we),
    .idx_i  (idx),
    .wdata_i(merged),
    .rdata_o(word)
  );

  assign rdata_o = (go && !wr_i) ? rrep : '0;

  // R4: non-memory cycles are fully quiet
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> !wait_o && !abort_o && !we && (rdata_o == '0));

  // R6: a rejected access never reaches the array
  a_r6_abort_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !we && (rdata_o == '0));
endmodule

// File: tb/bus_cycle_mem_tb.sv
module bus_cycle_mem_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mreq_n;
    logic        seq;
    logic        wr;
    logic [1:0]  size;
    logic        big;
    logic        lock;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  ewait;
    logic        eabort;
    logic [31:0] erd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,32'h0,32'h11223344,2'd2,1'b0,32'h0,4'd2},        // R2 N word write
    '{1'b0,1'b1,1'b1,2'd2,1'b0,1'b0,32'h4,32'h55667788,2'd0,1'b0,32'h0,4'd3},        // R3 +4
    '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h4,32'h0,2'd0,1'b0,32'h55667788,4'd3},        // R3 +0
    '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h0,32'h0,2'd2,1'b0,32'h11223344,4'd3},        // R3 -4 slow
    '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,32'h1,32'h0,2'd2,1'b0,32'h33333333,4'd8},        // R8 byte, +1 slow
    '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,32'h2,32'h0,2'd2,1'b0,32'h11221122,4'd7},        // R7 LE half
    '{1'b0,1'b1,1'b0,2'd1,1'b1,1'b0,32'h2,32'h0,2'd0,1'b0,32'h33443344,4'd7},        // R7 BE half
    '{1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,32'h3,32'h0,2'd2,1'b0,32'h44444444,4'd7},        // R7 BE byte
    '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,32'h5,32'h000000AA,2'd0,1'b0,32'h0,4'd11},       // R11 byte write +2
    '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h4,32'h0,2'd2,1'b0,32'h5566AA88,4'd11},       // R11 lanes kept
    '{1'b0,1'b1,1'b1,2'd1,1'b1,1'b0,32'h6,32'h0000BEEF,2'd0,1'b0,32'h0,4'd11},       // R11 BE half write
    '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h4,32'h0,2'd2,1'b0,32'h5566BEEF,4'd11},       // R11 check
    '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,32'h2,32'h0,2'd0,1'b1,32'h0,4'd6},               // R6 word misalign
    '{1'b0,1'b1,1'b1,2'd1,1'b0,1'b0,32'h5,32'h0000FFFF,2'd0,1'b1,32'h0,4'd6},        // R6 half misalign
    '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h4,32'h0,2'd0,1'b0,32'h5566BEEF,4'd6},        // R6 no write, prev kept
    '{1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,32'h4,32'h0,2'd0,1'b0,32'h0,4'd4},               // R4 internal
    '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,32'h4,32'h0,2'd0,1'b0,32'h0,4'd4},               // R4 coprocessor
    '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h4,32'h0,2'd0,1'b0,32'h5566BEEF,4'd4},        // R4 untouched
    '{1'b0,1'b0,1'b0,2'd3,1'b0,1'b0,32'h4,32'h0,2'd0,1'b1,32'h0,4'd5},               // R5 reserved size
    '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b1,32'h0,32'h0,2'd2,1'b0,32'h11223344,4'd9},        // R9 locked read
    '{1'b0,1'b0,1'b1,2'd2,1'b0,1'b1,32'h0,32'hCAFEF00D,2'd0,1'b0,32'h0,4'd9},        // R9 swap write fast
    '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,32'h0,32'h0,2'd2,1'b0,32'hCAFEF00D,4'd9},        // R9 unlocked read
    '{1'b0,1'b0,1'b1,2'd2,1'b0,1'b1,32'h0,32'h12345678,2'd2,1'b0,32'h0,4'd9}         // R9 no hold -> slow
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        mreq_n = 1'b1, seq = 1'b0, wr = 1'b0, lock = 1'b0, big = 1'b0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wait_s, abort_s;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_mem dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mreq_ni(mreq_n), .seq_i(seq),
    .wr_i(wr), .size_i(size), .lock_i(lock), .big_end_i(big), .wdata_i(wdata),
    .rdata_o(rdata), .wait_o(wait_s), .abort_o(abort_s)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int n);
    int waits = 0;
    @(negedge clk);
    mreq_n = v.mreq_n; seq = v.seq; wr = v.wr; size = v.size;
    big = v.big; lock = v.lock; addr = v.addr; wdata = v.wdata;
    #1;
    while (wait_s && waits < 6) begin
      @(negedge clk); #1; waits++;
    end
    check($sformatf("R%0d v%0d waits", v.req, n), 32'(waits), 32'(v.ewait));
    check($sformatf("R%0d v%0d abort", v.req, n), 32'(abort_s), 32'(v.eabort));
    check($sformatf("R%0d v%0d rdata", v.req, n), rdata, v.erd);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    #(CLK_PERIOD * 2 + 1);
    // R10 reset state with idle bus
    check("R10 reset wait", 32'(wait_s), 32'h0);
    check("R10 reset abort", 32'(abort_s), 32'h0);
    check("R10 reset rdata", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: reset mid-run forgets history, keeps memory
    @(negedge clk); mreq_n = 1'b1; lock = 1'b0; rst_n = 1'b0;
    #1;
    check("R10 in reset wait", 32'(wait_s), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    v = '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h0,32'h0,2'd2,1'b0,32'h12345678,4'd10};
    run_vec(v, 100);
    // R1: same address, code 01 now near -> fast; code 00 -> slow
    v = '{1'b0,1'b1,1'b0,2'd2,1'b0,1'b0,32'h0,32'h0,2'd0,1'b0,32'h12345678,4'd1};
    run_vec(v, 101);
    v = '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,32'h0,32'h0,2'd2,1'b0,32'h12345678,4'd1};
    run_vec(v, 102);
    // R8 LE byte lane 3 replicated
    v = '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,32'h3,32'h0,2'd2,1'b0,32'h12121212,4'd8};
    run_vec(v, 103);

    @(negedge clk); mreq_n = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule